// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block examines the two oldest decoded instructions waiting at the issue stage and decides how many of them may leave this cycle. The older one (slot A) always goes to the main pipe, which accepts any operation. The younger one (slot B) may go to a narrower secondary pipe in the same cycle, which accepts only simple operations. Pairing is allowed only when both are simple, slot A is not a branch, and the two carry no register conflict. If pairing is refused, slot A issues alone and slot B waits.

The pairing decision is made combinationally. The block also returns a consumed count at once, so the decode buffer knows how far to advance. The issued pair is captured in an output register, one descriptor per pipe. That register freezes while the downstream stall input is high, and no instruction is consumed during a stall.

Top module: `pair_issue_unit`

## Requirements
- R1: Slot B issues only when both slot A and slot B are marked simple. A complex slot A or a complex slot B forces a single issue.
- R2: When slot A is a branch, slot B does not issue in the same cycle.
- R3: Slot B does not issue when slot A's valid destination equals any valid source of slot B. A source whose valid bit is clear is never compared.
- R4: Slot B does not issue when both slots have a valid destination and the two indices are equal. A destination whose valid bit is clear is never compared.
- R5: A refused pair issues slot A alone to the main pipe with consumed_o = 1. A granted pair issues both slots with consumed_o = 2.
- R6: When slot B is not valid, slot A issues alone and consumed_o = 1.
- R7: When slot A is not valid, nothing issues and consumed_o = 0, whatever slot B holds.
- R8: While stall_i is high, consumed_o = 0. The issue strobes and both descriptors also keep their values across the clock edge.
- R9: While rst_ni is low, both strobes are low and both descriptors are zero.
- R10: The strobes and descriptors change on the clock edge after the inputs that produce them.
  - main_desc_o carries slot A and sec_desc_o carries slot B.
  - A pipe that receives nothing shows an all-zero descriptor.
  - Descriptor layout, MSB first: simple, branch, dest valid, dest index, source valid bits, source indices.
  - Source k occupies bits [k*IDX_W +: IDX_W], and its valid bit is the lowest bit of the valid field plus k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Downstream stall; freezes the issue register |
| a_valid_i | input | 1 | Slot A holds an instruction |
| a_simple_i | input | 1 | Slot A is a simple operation |
| a_branch_i | input | 1 | Slot A is a branch |
| a_dst_vld_i | input | 1 | Slot A writes a register |
| a_dst_i | input | IDX_W | Slot A destination index |
| a_src_vld_i | input | NUM_SRC | Slot A source valid bits |
| a_src_i | input | NUM_SRC*IDX_W | Slot A source indices |
| b_valid_i | input | 1 | Slot B holds an instruction |
| b_simple_i | input | 1 | Slot B is a simple operation |
| b_branch_i | input | 1 | Slot B is a branch |
| b_dst_vld_i | input | 1 | Slot B writes a register |
| b_dst_i | input | IDX_W | Slot B destination index |
| b_src_vld_i | input | NUM_SRC | Slot B source valid bits |
| b_src_i | input | NUM_SRC*IDX_W | Slot B source indices |
| consumed_o | output | 2 | Instructions taken this cycle (0, 1 or 2) |
| issue_main_o | output | 1 | Registered main-pipe issue strobe |
| issue_sec_o | output | 1 | Registered secondary-pipe issue strobe |
| main_desc_o | output | 3+IDX_W+NUM_SRC*(IDX_W+1) | Registered descriptor of slot A |
| sec_desc_o | output | 3+IDX_W+NUM_SRC*(IDX_W+1) | Registered descriptor of slot B |

## Verification
The bench builds the block with IDX_W = 5 and NUM_SRC = 2, but draws every random register index from 0 to 3. This makes destination-to-source and destination-to-destination matches frequent. It also makes the cases where a match is masked only by a clear valid bit frequent.

With two sources per instruction, a conflict can come through either source position independently. Stalls are injected about one cycle in eight, so held descriptors are compared against fresh inputs that would otherwise have changed them.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

  typedef enum logic [1:0] {
    ISS_NONE   = 2'd0,
    ISS_SINGLE = 2'd1,
    ISS_PAIR   = 2'd2
  } issue_kind_e;

  // number of instructions an issue decision removes from decode
  function automatic logic [1:0] take_count(issue_kind_e kind);
    case (kind)
      ISS_PAIR:   take_count = 2'd2;
      ISS_SINGLE: take_count = 2'd1;
      default:    take_count = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pair_hazard_detect.sv
module pair_hazard_detect #(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                     a_dst_vld,
  input  logic [IDX_W-1:0]         a_dst,
  input  logic                     b_dst_vld,
  input  logic [IDX_W-1:0]         b_dst,
  input  logic [NUM_SRC-1:0]       b_src_vld,
  input  logic [NUM_SRC*IDX_W-1:0] b_src,
  output logic                     raw_hit,
  output logic                     waw_hit
);

  logic [NUM_SRC-1:0] src_hit;

  // one comparator per source operand of the younger instruction
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src_cmp
    assign src_hit[k] = a_dst_vld && b_src_vld[k] &&
                        (a_dst == b_src[k*IDX_W +: IDX_W]);
  end

  assign raw_hit = |src_hit;
  assign waw_hit = a_dst_vld && b_dst_vld && (a_dst == b_dst);

endmodule

// File: rtl/pair_steer.sv
module pair_steer
  import pair_issue_pkg::*;
(
  input  logic        a_valid,
  input  logic        a_simple,
  input  logic        a_branch,
  input  logic        b_valid,
  input  logic        b_simple,
  input  logic        raw_hit,
  input  logic        waw_hit,
  input  logic        stall,
  output issue_kind_e kind,
  output logic        pair_ok,
  output logic [1:0]  consumed
);

  assign pair_ok = a_valid && b_valid && a_simple && b_simple &&
                   !a_branch && !raw_hit && !waw_hit;

  always_comb begin
    if (!a_valid)     kind = ISS_NONE;
    else if (pair_ok) kind = ISS_PAIR;
    else              kind = ISS_SINGLE;
  end

  assign consumed = stall ? 2'd0 : take_count(kind);

endmodule

// File: rtl/issue_hold_reg.sv
module issue_hold_reg #(
  parameter int DESC_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              main_d,
  input  logic              sec_d,
  input  logic [DESC_W-1:0] main_desc_d,
  input  logic [DESC_W-1:0] sec_desc_d,
  output logic              main_q,
  output logic              sec_q,
  output logic [DESC_W-1:0] main_desc_q,
  output logic [DESC_W-1:0] sec_desc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q      <= 1'b0;
      sec_q       <= 1'b0;
      main_desc_q <= '0;
      sec_desc_q  <= '0;
    end else if (load) begin
      main_q      <= main_d;
      sec_q       <= sec_d;
      main_desc_q <= main_desc_d;
      sec_desc_q  <= sec_desc_d;
    end
  end

  // R8: a stalled cycle leaves the issued pair untouched
  p_hold_when_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(main_q) && $stable(sec_q) &&
              $stable(main_desc_q) && $stable(sec_desc_q));

  // R10: an empty pipe shows a zero descriptor
  p_empty_desc_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_q |-> sec_desc_q == '0);

endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
  import pair_issue_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2,
  localparam int SRC_W  = NUM_SRC * IDX_W,
  localparam int DESC_W = 3 + IDX_W + NUM_SRC + SRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              a_valid_i,
  input  logic              a_simple_i,
  input  logic              a_branch_i,
  input  logic              a_dst_vld_i,
  input  logic [IDX_W-1:0]  a_dst_i,
  input  logic [NUM_SRC-1:0] a_src_vld_i,
  input  logic [SRC_W-1:0]  a_src_i,
  input  logic              b_valid_i,
  input  logic              b_simple_i,
  input  logic              b_branch_i,
  input  logic              b_dst_vld_i,
  input  logic [IDX_W-1:0]  b_dst_i,
  input  logic [NUM_SRC-1:0] b_src_vld_i,
  input  logic [SRC_W-1:0]  b_src_i,
  output logic [1:0]        consumed_o,
  output logic              issue_main_o,
  output logic              issue_sec_o,
  output logic [DESC_W-1:0] main_desc_o,
  output logic [DESC_W-1:0] sec_desc_o
);

  // descriptor field positions
  localparam int POS_SVLD   = SRC_W;
  localparam int POS_DST    = SRC_W + NUM_SRC;
  localparam int POS_DVLD   = DESC_W - 3;
  localparam int POS_BRANCH = DESC_W - 2;
  localparam int POS_SIMPLE = DESC_W - 1;

  logic        raw_hit, waw_hit, pair_ok;
  issue_kind_e kind;
  logic        go_main, go_sec;
  logic [DESC_W-1:0] a_desc, b_desc, main_next, sec_next;

  pair_hazard_detect #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) u_hazard (
    .a_dst_vld (a_dst_vld_i),
    .a_dst     (a_dst_i),
    .b_dst_vld (b_dst_vld_i),
    .b_dst     (b_dst_i),
    .b_src_vld (b_src_vld_i),
    .b_src     (b_src_i),
    .raw_hit   (raw_hit),
    .waw_hit   (waw_hit)
  );

  pair_steer u_steer (
    .a_valid  (a_valid_i),
    .a_simple (a_simple_i),
    .a_branch (a_branch_i),
    .b_valid  (b_valid_i),
    .b_simple (b_simple_i),
    .raw_hit  (raw_hit),
    .waw_hit  (waw_hit),
    .stall    (stall_i),
    .kind     (kind),
    .pair_ok  (pair_ok),
    .consumed (consumed_o)
  );

  assign a_desc = {a_simple_i, a_branch_i, a_dst_vld_i, a_dst_i, a_src_vld_i, a_src_i};
  assign b_desc = {b_simple_i, b_branch_i, b_dst_vld_i, b_dst_i, b_src_vld_i, b_src_i};

  assign go_main   = (kind != ISS_NONE);
  assign go_sec    = (kind == ISS_PAIR);
  assign main_next = go_main ? a_desc : '0;
  assign sec_next  = go_sec  ? b_desc : '0;

  issue_hold_reg #(.DESC_W(DESC_W)) u_hold (
    .clk         (clk_i),
    .rst_n       (rst_ni),
    .load        (!stall_i),
    .main_d      (go_main),
    .sec_d       (go_sec),
    .main_desc_d (main_next),
    .sec_desc_d  (sec_next),
    .main_q      (issue_main_o),
    .sec_q       (issue_sec_o),
    .main_desc_q (main_desc_o),
    .sec_desc_q  (sec_desc_o)
  );

  // R5: the secondary pipe never runs without the main pipe
  p_sec_needs_main_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_sec_o |-> issue_main_o);

  // R1: a paired issue holds two simple operations
  p_pair_both_simple_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_sec_o |-> main_desc_o[POS_SIMPLE] && sec_desc_o[POS_SIMPLE]);

  // R2: a branch in the main pipe is never paired
  p_branch_alone_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_sec_o |-> !main_desc_o[POS_BRANCH]);

  // R4: paired destinations never collide
  p_no_waw_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_sec_o && main_desc_o[POS_DVLD] && sec_desc_o[POS_DVLD]) |->
      main_desc_o[POS_DST +: IDX_W] != sec_desc_o[POS_DST +: IDX_W]);

  // R3: no paired source reads the main pipe's destination
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_raw_chk
    p_no_raw_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_sec_o && main_desc_o[POS_DVLD] && sec_desc_o[POS_SVLD + k]) |->
        main_desc_o[POS_DST +: IDX_W] != sec_desc_o[k*IDX_W +: IDX_W]);
  end

  // R8: nothing is consumed under stall
  p_stall_no_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> consumed_o == 2'd0);

  // R5: a count of two is followed by a paired issue
  p_two_means_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consumed_o == 2'd2) |=> issue_sec_o);

  // R7: an empty first slot issues nothing
  p_empty_a_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !a_valid_i) |=> !issue_main_o && !issue_sec_o);

endmodule

// File: tb/pair_issue_unit_tb.sv
module pair_issue_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 5;
  localparam int NS = 2;
  localparam int DW = 3 + W + NS + NS * W;

  typedef struct packed {
    logic          valid;
    logic          simple;
    logic          branch;
    logic          dvld;
    logic [W-1:0]  dst;
    logic [NS-1:0] svld;
    logic [NS*W-1:0] src;
  } slot_t;

  logic clk = 0, rst_n = 0, stall = 0;
  slot_t a, b;
  logic [1:0]    consumed;
  logic          iss_main, iss_sec;
  logic [DW-1:0] mdesc, sdesc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pair_issue_unit #(.IDX_W(W), .NUM_SRC(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
    .a_valid_i(a.valid), .a_simple_i(a.simple), .a_branch_i(a.branch),
    .a_dst_vld_i(a.dvld), .a_dst_i(a.dst), .a_src_vld_i(a.svld), .a_src_i(a.src),
    .b_valid_i(b.valid), .b_simple_i(b.simple), .b_branch_i(b.branch),
    .b_dst_vld_i(b.dvld), .b_dst_i(b.dst), .b_src_vld_i(b.svld), .b_src_i(b.src),
    .consumed_o(consumed), .issue_main_o(iss_main), .issue_sec_o(iss_sec),
    .main_desc_o(mdesc), .sec_desc_o(sdesc)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic          e_main, e_sec;
  logic [DW-1:0] e_mdesc, e_sdesc;
  string         prev_tag;

  function automatic slot_t mk(bit v, bit s, bit br, bit dv, int d, bit [1:0] sv, int s0, int s1);
    slot_t t;
    t.valid = v; t.simple = s; t.branch = br; t.dvld = dv;
    t.dst = W'(d); t.svld = sv; t.src = {W'(s1), W'(s0)};
    return t;
  endfunction

  // reads-after-write or writes-after-write between the slots
  function automatic bit clash(slot_t x, slot_t y);
    bit c = 0;
    if (x.dvld) begin
      for (int k = 0; k < NS; k++)
        if (y.svld[k] && y.src[k*W +: W] == x.dst) c = 1;
      if (y.dvld && y.dst == x.dst) c = 1;
    end
    return c;
  endfunction

  function automatic bit can_pair(slot_t x, slot_t y);
    if (!x.valid || !y.valid) return 0;
    if (!(x.simple && y.simple)) return 0;
    if (x.branch) return 0;
    return !clash(x, y);
  endfunction

  function automatic logic [DW-1:0] pack(slot_t s);
    return {s.simple, s.branch, s.dvld, s.dst, s.svld, s.src};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    chk(tag, "issue_main", 32'(iss_main), 32'(e_main));
    chk(tag, "issue_sec",  32'(iss_sec),  32'(e_sec));
    chk(tag, "main_desc",  32'(mdesc),    32'(e_mdesc));
    chk(tag, "sec_desc",   32'(sdesc),    32'(e_sdesc));
  endtask

  // one cycle: check previous capture, drive new inputs, check count
  task automatic step(slot_t na, slot_t nb, bit st, string tag);
    bit p, m;
    @(negedge clk);
    chk_regs(prev_tag);
    a = na; b = nb; stall = st;
    #1;
    p = can_pair(na, nb);
    m = na.valid;
    chk(tag, "consumed", 32'(consumed), st ? 32'd0 : (p ? 32'd2 : (m ? 32'd1 : 32'd0)));
    if (!st) begin
      e_main  = m;
      e_sec   = p;
      e_mdesc = m ? pack(na) : '0;
      e_sdesc = p ? pack(nb) : '0;
    end
    prev_tag = tag;
  endtask

  function automatic slot_t rnd_slot();
    return mk($urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0,
              $urandom_range(0, 4) == 0, $urandom_range(0, 3) != 0,
              $urandom_range(0, 3), 2'($urandom_range(0, 3)),
              $urandom_range(0, 3), $urandom_range(0, 3));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    slot_t p, q;
    void'($urandom(32'd4711));
    a = '0; b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9", "issue_main", 32'(iss_main), 32'd0);
    chk("R9", "issue_sec",  32'(iss_sec),  32'd0);
    chk("R9", "main_desc",  32'(mdesc),    32'd0);
    chk("R9", "sec_desc",   32'(sdesc),    32'd0);
    rst_n = 1;
    e_main = 0; e_sec = 0; e_mdesc = '0; e_sdesc = '0; prev_tag = "R9";

    p = mk(1, 1, 0, 1, 1, 2'b11, 2, 3);
    q = mk(1, 1, 0, 1, 4, 2'b11, 5, 6);
    step(p, q, 0, "R5_pair");
    step(mk(1, 0, 0, 1, 1, 2'b11, 2, 3), q, 0, "R1_a_complex");
    step(p, mk(1, 0, 0, 1, 4, 2'b11, 5, 6), 0, "R1_b_complex");
    step(mk(1, 1, 1, 0, 0, 2'b00, 0, 0), q, 0, "R2_branch");
    step(p, mk(1, 1, 1, 1, 4, 2'b11, 5, 6), 0, "R10_b_branch_ok");
    step(p, mk(1, 1, 0, 1, 4, 2'b11, 1, 6), 0, "R3_src0");
    step(p, mk(1, 1, 0, 1, 4, 2'b11, 5, 1), 0, "R3_src1");
    step(p, mk(1, 1, 0, 1, 4, 2'b10, 1, 6), 0, "R3_src_masked");
    step(mk(1, 1, 0, 0, 5, 2'b11, 2, 3), mk(1, 1, 0, 1, 4, 2'b11, 5, 6), 0, "R3_dst_masked");
    step(p, mk(1, 1, 0, 1, 1, 2'b00, 0, 0), 0, "R4_waw");
    step(p, mk(1, 1, 0, 0, 1, 2'b00, 0, 0), 0, "R4_waw_masked");
    step(p, mk(0, 1, 0, 1, 4, 2'b11, 5, 6), 0, "R6_b_empty");
    step(mk(0, 1, 0, 1, 1, 2'b11, 2, 3), q, 0, "R7_a_empty");
    step(p, q, 0, "R5_pair");
    step(mk(1, 0, 1, 1, 7, 2'b01, 8, 9), mk(0, 0, 0, 0, 0, 2'b00, 0, 0), 1, "R8_stall");
    step(mk(0, 0, 0, 0, 0, 2'b00, 0, 0), q, 1, "R8_stall");
    step(mk(1, 0, 0, 1, 3, 2'b01, 2, 0), q, 0, "R10_after_stall");

    for (int i = 0; i < 3000; i++)
      step(rnd_slot(), rnd_slot(), $urandom_range(0, 7) == 0, "R5_random");
    step('0, '0, 0, "R7_drain");
    @(negedge clk);
    chk_regs(prev_tag);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule